// File: doc/BRIEF.md
# Interleaved Bank Access Controller

This block connects a processor-side request port to four independent 32-bit memory banks and serves two kinds of read. A cacheable request becomes a line refill: all four banks are read at the same index and one 128-bit response carries the four words. A request that skips the cache becomes a single-word load. A request skips the cache when its bypass flag is set or when its address lies in the uncached window defined by a base and a mask. A single-word load reads only the bank picked by the address.

Each bank is a timed storage array with a small state machine. Its states are `B_IDLE`, `B_ACCESS` and `B_RECOVER`. The transitions are: start (idle to access), data delivered (access to recover), recovery done (recover to idle), and restart (last recover cycle straight back to access). A bank accepts a new access only when it is idle or in its final recovery cycle. A request to a free bank is accepted at once, so single-word loads to different banks overlap. A request to a bank that is still busy is stalled. A line refill waits until every bank is free. Responses leave through a valid/ready port in the order the requests were accepted. A bounded response queue limits how many requests may be outstanding.

Top module: `ibank_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is 0. `req_ready` is 1 for any request, because every bank starts free and no response is outstanding.
- R2: A single-word load uses bank `req_addr[3:2]` and in-bank index `req_addr[7:4]`. Its response has `rsp_line` = 0, the word in `rsp_data[31:0]`, and the upper 96 bits zero. Word `i` of bank `b` holds `{4'hB, 2'b00, b[1:0], 8'h00, i[7:0], ~i[7:0]}`.
- R3: A request is a single-word load if `req_bypass` = 1 or if `(req_addr & UC_MASK) == UC_BASE`; otherwise it is a line refill. A line refill response has `rsp_line` = 1 and `rsp_data` = {bank3, bank2, bank1, bank0} words at index `req_addr[7:4]`.
- R4: A response first shows `rsp_valid` ACC_CYC clock edges after the edge that accepted its request, if no earlier response is still waiting.
- R5: Once a bank has been started, it cannot be started again until ACC_CYC+REC_CYC edges later. A request to it holds `req_ready` low until then.
- R6: A single-word load to a free bank is accepted even while other banks are still accessing or recovering. Back-to-back loads to four different banks are accepted on consecutive edges.
- R7: A line refill is accepted only when all four banks are free, and it starts all four banks.
- R8: Responses leave in acceptance order. While `rsp_valid` = 1 and `rsp_ready` = 0, the response holds steady.
- R9: No request is accepted while RSP_DEPTH accepted responses have not yet been taken at the response port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_bypass | input | 1 | 1 = load that skips the cache |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_line | output | 1 | 1 = 128-bit line response, 0 = single word |
| rsp_data | output | 128 | Response data |

## Verification
The bench drives a range of traffic patterns through a behavioural model that keeps each bank's earliest restart cycle and a queue of pending responses.
- A lone bypass load and a lone uncached load separate the two reasons for skipping the cache. They also show the bank and index decode.
- Repeated loads to one bank expose the recovery stall. A sweep across four banks shows that the banks overlap.
- A line refill issued right behind word loads shows the all-banks-free rule.
- A burst with the response port held off fills the response queue, which tests the outstanding limit and the hold behaviour.
- A long random mix with random back-pressure checks ordering against the model.

// File: rtl/ibank_pkg.sv
package ibank_pkg;

    localparam int NBANK  = 4;
    localparam int WORD_W = 32;
    localparam int LINE_W = NBANK * WORD_W;
    localparam int SEL_W  = $clog2(NBANK);

    typedef enum logic [1:0] {
        B_IDLE    = 2'd0,
        B_ACCESS  = 2'd1,
        B_RECOVER = 2'd2
    } bank_state_e;

    typedef struct packed {
        logic             vld;
        logic             line;
        logic [SEL_W-1:0] bank;
    } rsp_tag_t;

    function automatic logic [WORD_W-1:0] init_word(input logic [1:0] b, input logic [7:0] i);
        return {4'hB, 2'b00, b, 8'h00, i, ~i};
    endfunction

endpackage

// File: rtl/ibank_bank.sv
module ibank_bank
    import ibank_pkg::*;
#(
    parameter int ACC_CYC    = 5,
    parameter int REC_CYC    = 5,
    parameter int BANK_WORDS = 16,
    parameter int BANK_ID    = 0,
    localparam int IDX_W     = $clog2(BANK_WORDS),
    localparam int CNT_MAX   = (ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              free_o,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o
);

    bank_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] mem [BANK_WORDS];

    // storage array, loaded with a fixed pattern at reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_WORDS; i++) begin
                mem[i] <= init_word(2'(BANK_ID), 8'(i));
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start_i) begin
                data_q <= mem[idx_i];
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            B_IDLE: begin
                if (start_i) begin
                    state_d = B_ACCESS;
                    cnt_d   = CNT_W'(ACC_CYC - 1);
                end
            end
            B_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d = B_RECOVER;
                    cnt_d   = CNT_W'(REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            B_RECOVER: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (start_i) begin
                    state_d = B_ACCESS;
                    cnt_d   = CNT_W'(ACC_CYC - 1);
                end else begin
                    state_d = B_IDLE;
                end
            end
            default: begin
                state_d = B_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        free_o     = (state_q == B_IDLE) || (state_q == B_RECOVER && cnt_q == '0);
        rd_valid_o = (state_q == B_ACCESS) && (cnt_q == '0);
        rd_data_o  = data_q;
    end

    // R5: the controller never starts a bank that is mid access or recovery
    p_start_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == B_IDLE || (state_q == B_RECOVER && cnt_q == '0)));

    // R5: a started bank reports busy on the following cycle
    p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !free_o);

    // R4: delivered data is followed by recovery
    p_read_then_recover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> (state_q == B_RECOVER || state_q == B_ACCESS) && !rd_valid_o || REC_CYC == 0);

endmodule

// File: rtl/ibank_rsp_fifo.sv
module ibank_rsp_fifo #(
    parameter int W     = 129,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic             valid_o,
    output logic [W-1:0]     data_o,
    output logic [CNT_W-1:0] count_o
);

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop;

    assign do_pop = pop_i && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            slot[wr_q] <= data_i;
        end
    end

    assign valid_o = (cnt_q != '0);
    assign data_o  = slot[rd_q];
    assign count_o = cnt_q;

    // R9: credits keep the queue from ever overflowing
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CNT_W'(DEPTH)) || do_pop);

endmodule

// File: rtl/ibank_ctrl.sv
module ibank_ctrl
    import ibank_pkg::*;
#(
    parameter int          ACC_CYC    = 5,
    parameter int          REC_CYC    = 5,
    parameter int          BANK_WORDS = 16,
    parameter int          RSP_DEPTH  = 8,
    parameter logic [31:0] UC_BASE    = 32'h8000_0000,
    parameter logic [31:0] UC_MASK    = 32'hF000_0000,
    localparam int         IDX_W      = $clog2(BANK_WORDS),
    localparam int         CNT_W      = $clog2(RSP_DEPTH + 1) + 1,
    localparam int         FCNT_W     = $clog2(RSP_DEPTH + 1),
    localparam int         ENT_W      = 1 + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic              req_bypass,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_line,
    output logic [LINE_W-1:0] rsp_data
);

    logic [SEL_W-1:0]  sel;
    logic [IDX_W-1:0]  idx;
    logic              uncached, is_word, bank_ok, credit_ok, accept;
    logic [NBANK-1:0]  bank_free, bank_start, bank_rdv;
    logic [WORD_W-1:0] bank_data [NBANK];
    rsp_tag_t          tag_q [ACC_CYC];
    rsp_tag_t          tag_out;
    logic [CNT_W-1:0]  inflight_q;
    logic [FCNT_W-1:0] fifo_cnt;
    logic [ENT_W-1:0]  push_ent, head_ent;
    logic [LINE_W-1:0] line_word;

    // request decode and bypass decision
    always_comb begin
        sel       = req_addr[3:2];
        idx       = req_addr[4 +: IDX_W];
        uncached  = (req_addr & UC_MASK) == UC_BASE;
        is_word   = req_bypass || uncached;
        bank_ok   = is_word ? bank_free[sel] : (&bank_free);
        credit_ok = (inflight_q + CNT_W'(fifo_cnt)) < CNT_W'(RSP_DEPTH);
        req_ready = bank_ok && credit_ok;
        accept    = req_valid && req_ready;
        for (int b = 0; b < NBANK; b++) begin
            bank_start[b] = accept && (!is_word || sel == SEL_W'(b));
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ibank_bank #(
            .ACC_CYC   (ACC_CYC),
            .REC_CYC   (REC_CYC),
            .BANK_WORDS(BANK_WORDS),
            .BANK_ID   (b)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (bank_start[b]),
            .idx_i     (idx),
            .free_o    (bank_free[b]),
            .rd_valid_o(bank_rdv[b]),
            .rd_data_o (bank_data[b])
        );
        assign line_word[b*WORD_W +: WORD_W] = bank_data[b];
    end

    // tag pipeline: same depth as the access time keeps responses in order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ACC_CYC; k++) begin
                tag_q[k] <= '0;
            end
            inflight_q <= '0;
        end else begin
            tag_q[0] <= '{vld: accept, line: !is_word, bank: sel};
            for (int k = 1; k < ACC_CYC; k++) begin
                tag_q[k] <= tag_q[k-1];
            end
            inflight_q <= inflight_q + CNT_W'(accept) - CNT_W'(tag_q[ACC_CYC-1].vld);
        end
    end

    assign tag_out  = tag_q[ACC_CYC-1];
    assign push_ent = tag_out.line ? {1'b1, line_word}
                                   : {1'b0, {(LINE_W-WORD_W){1'b0}}, bank_data[tag_out.bank]};

    ibank_rsp_fifo #(
        .W    (ENT_W),
        .DEPTH(RSP_DEPTH)
    ) u_rsp_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (tag_out.vld),
        .data_i (push_ent),
        .pop_i  (rsp_ready),
        .valid_o(rsp_valid),
        .data_o (head_ent),
        .count_o(fifo_cnt)
    );

    assign rsp_line = head_ent[LINE_W];
    assign rsp_data = head_ent[LINE_W-1:0];

    // R7: a line refill starts only when every bank reports free
    p_line_needs_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_word) |-> (&bank_free));

    // R6: a word load starts exactly one bank
    p_word_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_word) |-> ($countones(bank_start) == 1));

    // R4: the tag leaving the pipeline meets the banks' data
    p_tag_meets_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_out.vld |-> (tag_out.line ? (&bank_rdv) : bank_rdv[tag_out.bank]));

    // R8: a stalled response holds steady
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_line)));

    // R9: outstanding responses never exceed the queue depth
    p_credit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q + CNT_W'(fifo_cnt)) <= CNT_W'(RSP_DEPTH));

endmodule

// File: tb/ibank_ctrl_bench.sv
module ibank_ctrl_bench;

    localparam int ACC   = 5;
    localparam int REC   = 5;
    localparam int DEPTH = 8;
    localparam logic [31:0] UCB = 32'h8000_0000;
    localparam logic [31:0] UCM = 32'hF000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_bypass = 1'b0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic         rsp_line;
    logic [127:0] rsp_data;

    always #2 clk = ~clk;

    ibank_ctrl #(
        .ACC_CYC(ACC), .REC_CYC(REC), .BANK_WORDS(16), .RSP_DEPTH(DEPTH),
        .UC_BASE(UCB), .UC_MASK(UCM)
    ) u_ibank_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_bypass(req_bypass),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    typedef struct {
        logic         line;
        logic [127:0] data;
        int           avail;
    } exp_rsp_t;

    exp_rsp_t q[$];
    int nf[4];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int rr_mode = 0;  // 0: always ready, 1: never ready, 2: random
    bit done = 0;

    function automatic logic [31:0] wexp(input int b, input int i);
        logic [7:0] ii;
        ii = 8'(i);
        return {4'hB, 2'b00, 2'(b), 8'h00, ii, ~ii};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare with the model, advance it
    task automatic step(input logic v, input logic [31:0] a, input logic byp, output bit acc);
        int b, idx;
        bit word, bank_ok, credit_ok, exp_ready, exp_rv, rr;
        string tag;
        @(negedge clk);
        cyc++;
        rr = (rr_mode == 0) ? 1'b1 : (rr_mode == 1) ? 1'b0 : 1'($urandom_range(0, 1));
        req_valid = v; req_addr = a; req_bypass = byp; rsp_ready = rr;
        #1;
        b    = int'(a[3:2]);
        idx  = int'(a[7:4]);
        word = byp || ((a & UCM) == UCB);
        if (word) bank_ok = (cyc + 1 >= nf[b]);
        else      bank_ok = (cyc + 1 >= nf[0]) && (cyc + 1 >= nf[1]) &&
                            (cyc + 1 >= nf[2]) && (cyc + 1 >= nf[3]);
        credit_ok = (q.size() < DEPTH);
        exp_ready = bank_ok && credit_ok;
        if (!credit_ok)   tag = "R9";
        else if (!word)   tag = "R7";
        else if (!bank_ok) tag = "R5";
        else              tag = "R6";
        chk(req_ready === exp_ready, tag, "req_ready", 128'(req_ready), 128'(exp_ready));
        exp_rv = (q.size() > 0) && (q[0].avail <= cyc);
        chk(rsp_valid === exp_rv, "R4", "rsp_valid", 128'(rsp_valid), 128'(exp_rv));
        if (exp_rv) begin
            chk(rsp_line === q[0].line, "R3", "rsp_line", 128'(rsp_line), 128'(q[0].line));
            chk(rsp_data === q[0].data, q[0].line ? "R3" : "R2", "rsp_data (R8 order)",
                rsp_data, q[0].data);
        end
        if (exp_rv && rr) void'(q.pop_front());
        acc = v && exp_ready;
        if (acc) begin
            exp_rsp_t e;
            e.line  = !word;
            e.avail = cyc + 1 + ACC;
            if (word) begin
                e.data = {96'h0, wexp(b, idx)};
                nf[b] = cyc + 1 + ACC + REC;
            end else begin
                e.data = {wexp(3, idx), wexp(2, idx), wexp(1, idx), wexp(0, idx)};
                for (int k = 0; k < 4; k++) nf[k] = cyc + 1 + ACC + REC;
            end
            q.push_back(e);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic byp);
        bit acc;
        acc = 0;
        for (int n = 0; n < 200 && !acc; n++) step(1'b1, a, byp, acc);
        if (!acc) chk(1'b0, "R5", "request never accepted", 0, 1);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int k = 0; k < n; k++) step(1'b0, 32'h0, 1'b0, acc);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) nf[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 128'(rsp_valid), 0);
        chk(req_ready === 1'b1, "R1", "req_ready after reset", 128'(req_ready), 1);

        // R2, R4: lone bypass load to bank 1, index 3
        issue(32'h0000_0034, 1'b1);
        idle(ACC + 3);
        // R3: uncached address without bypass flag gives a word
        issue(32'h8000_0058, 1'b0);
        idle(ACC + 3);
        // R3: cacheable line refill
        issue(32'h0000_00A0, 1'b0);
        idle(ACC + REC + 2);
        // R5: same bank back to back
        issue(32'h0000_0008, 1'b1);
        issue(32'h0000_0018, 1'b1);
        issue(32'h0000_0028, 1'b1);
        idle(ACC + REC + 2);
        // R6: four banks on consecutive edges
        for (int k = 0; k < 4; k++) issue(32'h0000_0040 + 32'(4 * k), 1'b1);
        // R7: line refill right behind word loads waits for all banks
        issue(32'h0000_00F0, 1'b0);
        issue(32'h0000_0060, 1'b0);
        idle(ACC + REC + 2);
        // R9, R8: response port held off until the queue fills
        rr_mode = 1;
        for (int k = 0; k < DEPTH; k++) issue(32'h0000_0000 + 32'(4 * (k % 4)) + 32'(16 * k), 1'b1);
        begin
            bit acc;
            for (int k = 0; k < ACC + REC + 6; k++) step(1'b1, 32'h0000_0074, 1'b1, acc);
        end
        rr_mode = 0;
        issue(32'h0000_0074, 1'b1);
        idle(ACC + 4);
        // mixed traffic with random back-pressure
        rr_mode = 2;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int kind;
            kind = $urandom_range(0, 9);
            a = {24'h0, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 2'b00};
            if (kind == 0)      issue(a, 1'b0);
            else if (kind == 1) issue(a | UCB, 1'b0);
            else                issue(a, 1'b1);
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        rr_mode = 0;
        idle(ACC + DEPTH + 4);
        finish_run();
    end

endmodule